// File: doc/BRIEF.md
# Three-wire addressed control receiver

This block takes configuration writes from a host over a three-wire serial bus (bit clock, data and a framing mode line) and keeps them in two small banks of 6-bit control registers. A system clock much faster than the bus clock oversamples all three lines. Each bit is taken on a rising edge of the bus clock, and bits are gathered into bytes. The banks are driven out as flat parallel vectors, so downstream logic can use them without a handshake.

While the mode line is low, a byte is an address byte. It names a device and picks a register group. While the mode line is high, a byte is a data byte. It carries a 2-bit register index and a 6-bit value for the group picked last. The device and group choice stays in force until the next address byte. A host can therefore stream any number of data bytes after one address.

Top module: `ctl3w_rx`

## Requirements
- R1: After reset, every bit of both register banks is 0 and the device is deselected. Data bytes that arrive before any matching address byte change nothing.
- R2: A byte sent with the mode line low is an address byte. Its 8 bits arrive most significant bit first. Bits 7..2 are the device address, and the device responds only to 6'b000101.
- R3: An address byte with any other device address deselects the device. Every data byte after it is then ignored until a matching address byte arrives.
- R4: Address bits 1..0 pick the group. 2'b00 selects the data bank and 2'b10 selects the status bank.
- R5: If the group code is 2'b01 or 2'b11, data bytes leave both banks unchanged.
- R6: In a data byte (mode line high), bits 7..6 pick register 0..3 of the selected group and bits 5..0 are the value written. Register k appears at bits [6k+5:6k] of its bank output.
- R7: The device and group selection stays in force across any number of consecutive data bytes.
- R8: A register is written only after the eighth bit of a byte. If the mode line changes before the eighth bit, the partial byte is dropped: a partial data byte writes nothing, and a partial address byte leaves the selection unchanged.
- R9: A bit takes the value of the data line at the rising edge of the bus clock. Changes on the data line while the bus clock is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bus bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial bus data line (asynchronous) |
| ser_mode_i | input | 1 | Framing line: low for address bytes, high for data bytes |
| data_regs_o | output | 24 | Data bank, four 6-bit registers packed with register 0 in the low bits |
| stat_regs_o | output | 24 | Status bank, same packing |

## Verification
The hardest case to reach is a byte cut short by a mode-line change in the middle of its bits. The bit counter is hidden, so only later bytes show whether the partial bits were dropped or left in the byte assembly. The stimulus sends partial data and partial address bytes. It then flips the mode line and sends full bytes whose effects depend on the counter having restarted: a correct write, and a selection that still holds. Glitches on the data line while the bus clock is high are also injected, to show that sampling happens only on the rising edge.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int BYTE_W = 8;
  localparam int TYPE_W = 2;
  localparam int IDX_W  = 2;
  localparam int VAL_W  = BYTE_W - IDX_W;
  localparam int DEV_W  = BYTE_W - TYPE_W;

  typedef enum logic [TYPE_W-1:0] {
    XFER_DATA = 2'b00,
    XFER_RSV1 = 2'b01,
    XFER_STAT = 2'b10,
    XFER_RSV3 = 2'b11
  } xfer_e;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              smode,
  output logic              byte_vld,
  output logic              byte_mode,
  output logic [BYTE_W-1:0] byte_bits
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic             sclk_d, smode_d;
  logic [CNT_W-1:0] cnt;
  logic             rise, mode_chg;

  assign rise     = sclk & ~sclk_d;
  assign mode_chg = smode ^ smode_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      smode_d   <= 1'b0;
      cnt       <= '0;
      byte_vld  <= 1'b0;
      byte_mode <= 1'b0;
      byte_bits <= '0;
    end else begin
      sclk_d   <= sclk;
      smode_d  <= smode;
      byte_vld <= 1'b0;
      if (mode_chg) begin
        cnt <= '0;
      end else if (rise) begin
        byte_bits <= {byte_bits[BYTE_W-2:0], sdat};
        if (cnt == LAST) begin
          cnt       <= '0;
          byte_vld  <= 1'b1;
          byte_mode <= smode;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_byte_after_edge_r8: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> ($past(rise) && !$past(mode_chg)))
    else $error("byte completed without a clean bus clock edge");
endmodule

// File: rtl/ctl3w_decode.sv
module ctl3w_decode
  import ctl3w_pkg::*;
#(
  parameter int              BYTE_W = 8,
  parameter int              IDX_W  = 2,
  parameter int              TYPE_W = 2,
  parameter logic [BYTE_W-TYPE_W-1:0] DEV_ID = 6'b000101
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_vld,
  input  logic                    byte_mode,
  input  logic [BYTE_W-1:0]       byte_bits,
  output logic                    wr_en,
  output xfer_e                   wr_grp,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [BYTE_W-IDX_W-1:0] wr_val
);
  logic  sel;
  xfer_e grp;
  logic  grp_ok;

  assign grp_ok = (grp == XFER_DATA) || (grp == XFER_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= 1'b0;
      grp    <= XFER_DATA;
      wr_en  <= 1'b0;
      wr_grp <= XFER_DATA;
      wr_idx <= '0;
      wr_val <= '0;
    end else begin
      wr_en <= byte_vld && byte_mode && sel && grp_ok;
      if (byte_vld && !byte_mode) begin
        sel <= (byte_bits[BYTE_W-1:TYPE_W] == DEV_ID);
        grp <= xfer_e'(byte_bits[TYPE_W-1:0]);
      end
      if (byte_vld && byte_mode) begin
        wr_grp <= grp;
        wr_idx <= byte_bits[BYTE_W-1 -: IDX_W];
        wr_val <= byte_bits[BYTE_W-IDX_W-1:0];
      end
    end
  end

  p_deselect_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !byte_mode && byte_bits[BYTE_W-1:TYPE_W] != DEV_ID) |=> !sel)
    else $error("foreign address left device selected");

  p_rsv_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_mode && (grp == XFER_RSV1 || grp == XFER_RSV3)) |=> !wr_en)
    else $error("write issued for unused transfer type");

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_mode) |=> ($stable(sel) && $stable(grp)))
    else $error("data byte altered selection");
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
  import ctl3w_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int VAL_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  xfer_e                       wr_grp,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [VAL_W-1:0]            wr_val,
  output logic [(1<<IDX_W)*VAL_W-1:0] data_regs_o,
  output logic [(1<<IDX_W)*VAL_W-1:0] stat_regs_o
);
  localparam int NREG = 1 << IDX_W;
  localparam int NGRP = 2;

  logic [NGRP*NREG-1:0] we_vec;
  logic [VAL_W-1:0]     bank_q [NGRP][NREG];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam xfer_e CODE = (g == 0) ? XFER_DATA : XFER_STAT;
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign we_vec[g*NREG + r] = wr_en && (wr_grp == CODE) &&
                                  (wr_idx == IDX_W'(r));
      always_ff @(posedge clk) begin
        if (rst) bank_q[g][r] <= '0;
        else if (we_vec[g*NREG + r]) bank_q[g][r] <= wr_val;
      end
      if (g == 0) begin : g_dout
        assign data_regs_o[r*VAL_W +: VAL_W] = bank_q[g][r];
      end else begin : g_sout
        assign stat_regs_o[r*VAL_W +: VAL_W] = bank_q[g][r];
      end
    end
  end

  p_onehot_we_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_vec))
    else $error("more than one register enabled");

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(data_regs_o) && $stable(stat_regs_o)))
    else $error("register changed without a write");
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ID = 6'b000101
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_clk_i,
  input  logic        ser_dat_i,
  input  logic        ser_mode_i,
  output logic [23:0] data_regs_o,
  output logic [23:0] stat_regs_o
);
  logic [2:0]        line_s;
  logic              byte_vld, byte_mode;
  logic [BYTE_W-1:0] byte_bits;
  logic              wr_en;
  xfer_e             wr_grp;
  logic [IDX_W-1:0]  wr_idx;
  logic [VAL_W-1:0]  wr_val;
  logic              rst_d;

  ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_mode_i, ser_dat_i, ser_clk_i}),
    .q(line_s)
  );

  ctl3w_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk(line_s[0]), .sdat(line_s[1]), .smode(line_s[2]),
    .byte_vld(byte_vld), .byte_mode(byte_mode), .byte_bits(byte_bits)
  );

  ctl3w_decode #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .TYPE_W(TYPE_W),
                 .DEV_ID(DEV_ID)) u_dec (
    .clk(clk), .rst(rst),
    .byte_vld(byte_vld), .byte_mode(byte_mode), .byte_bits(byte_bits),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  ctl3w_regbank #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_val(wr_val),
    .data_regs_o(data_regs_o), .stat_regs_o(stat_regs_o)
  );

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d && !rst) begin
      p_reset_clear_r1: assert (data_regs_o == '0 && stat_regs_o == '0)
        else $error("banks not cleared by reset");
    end
  end
endmodule

// File: tb/ctl3w_rx_bench.sv
module ctl3w_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_mode = 1'b0;
  logic [23:0] data_regs, stat_regs;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [23:0] d;
    logic [23:0] s;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [5:0] dm [4];
  logic [5:0] sm [4];
  bit         m_sel = 0;
  logic [1:0] m_grp = 2'b00;

  always #4 clk = ~clk;

  ctl3w_rx u_ctl3w_rx (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_mode_i(ser_mode),
    .data_regs_o(data_regs), .stat_regs_o(stat_regs)
  );

  function automatic logic [23:0] pack(input logic [5:0] a [4]);
    logic [23:0] v;
    for (int k = 0; k < 4; k++) v[k*6 +: 6] = a[k];
    return v;
  endfunction

  task automatic bit_out(input logic b, input bit glitch);
    ser_dat = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (2) @(negedge clk);
    if (glitch) ser_dat = ~b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
    ser_dat = b;
  endtask

  task automatic send(input logic mode, input logic [7:0] b, input int nbits,
                      input bit glitch, input string tag);
    exp_t e;
    ser_mode = mode;
    repeat (4) @(negedge clk);
    for (int i = 7; i > 7 - nbits; i--) bit_out(b[i], glitch);
    if (nbits == 8) begin
      if (!mode) begin
        m_sel = (b[7:2] == 6'b000101);
        m_grp = b[1:0];
      end else if (m_sel) begin
        if (m_grp == 2'b00) dm[b[7:6]] = b[5:0];
        else if (m_grp == 2'b10) sm[b[7:6]] = b[5:0];
      end
    end
    e.d = pack(dm); e.s = pack(sm); e.tag = tag;
    q.push_back(e);
    repeat (12) @(negedge clk);
  endtask

  // monitor: compares design outputs against queued expectations
  initial begin
    exp_t e;
    forever begin
      wait (q.size() > 0);
      repeat (6) @(negedge clk);
      e = q.pop_front();
      checks++;
      if (data_regs !== e.d || stat_regs !== e.s) begin
        errors++;
        $display("FAIL %s: data=%h stat=%h expected data=%h stat=%h",
                 e.tag, data_regs, stat_regs, e.d, e.s);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin dm[k] = '0; sm[k] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (data_regs !== '0 || stat_regs !== '0) begin
      errors++;
      $display("FAIL R1: data=%h stat=%h expected 0 0", data_regs, stat_regs);
    end
    // R1: deselected after reset
    send(1, 8'b01_101010, 8, 0, "R1 data before address");
    // R2/R4/R6/R7: select data group, stream several bytes
    send(0, {6'b000101, 2'b00}, 8, 0, "R2 address byte");
    send(1, {2'd0, 6'h15}, 8, 0, "R6 write data reg0");
    send(1, {2'd3, 6'h3F}, 8, 0, "R7 second byte same selection");
    send(1, {2'd1, 6'h2A}, 8, 0, "R7 third byte same selection");
    // R4: status group
    send(0, {6'b000101, 2'b10}, 8, 0, "R4 address status");
    send(1, {2'd2, 6'h11}, 8, 0, "R4 write status reg2");
    send(1, {2'd0, 6'h0E}, 8, 0, "R6 write status reg0");
    // R5: unused types
    send(0, {6'b000101, 2'b01}, 8, 0, "R5 address type 01");
    send(1, {2'd0, 6'h07}, 8, 0, "R5 no write under 01");
    send(0, {6'b000101, 2'b11}, 8, 0, "R5 address type 11");
    send(1, {2'd2, 6'h09}, 8, 0, "R5 no write under 11");
    // R3: foreign addresses
    send(0, {6'b000110, 2'b00}, 8, 0, "R3 foreign address");
    send(1, {2'd0, 6'h01}, 8, 0, "R3 ignored after foreign");
    send(0, {6'b100101, 2'b10}, 8, 0, "R3 msb differs");
    send(1, {2'd1, 6'h02}, 8, 0, "R3 ignored after msb mismatch");
    // R8: partial data byte, then restart
    send(0, {6'b000101, 2'b00}, 8, 0, "R2 reselect data");
    send(1, {2'd0, 6'h01}, 5, 0, "R8 partial data byte dropped");
    send(0, {6'b000101, 2'b00}, 8, 0, "R8 address after partial");
    send(1, {2'd0, 6'h33}, 8, 0, "R8 full byte after partial");
    // R8: partial address keeps selection
    send(0, {6'b000110, 2'b00}, 6, 0, "R8 partial address dropped");
    send(1, {2'd1, 6'h05}, 8, 0, "R8 selection kept after partial address");
    // R9: data glitches while bus clock high
    send(1, {2'd2, 6'h0C}, 8, 1, "R9 glitch while clock high");
    send(1, {2'd3, 6'h30}, 8, 1, "R9 second glitched byte");
    wait (q.size() == 0);
    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule